// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the transmit half of a packet DMA engine. Software builds a ring of 32-byte descriptors in memory, hands each one to hardware by setting its ownership flag, and then pulses a poll strobe. The walker starts at its current ring pointer and fetches each descriptor one 32-bit word at a time over a plain request/ready memory port. For each owned descriptor it checks the buffer lengths and copies the buffer bytes into an on-chip staging store. When a descriptor carries the last-segment flag, it sends the whole staged frame out on a byte stream.

After a descriptor has been consumed, its control word is written back with ownership returned to software. The ring pointer then either moves to the next 32-byte slot or returns to the ring base, as the descriptor's end-of-ring flag directs. The walk stops at the first descriptor that hardware does not own. It aborts without a write-back when a descriptor breaks a length rule. A poll that arrives during a walk is remembered and causes one further walk.

The register file that holds the base address, the MAC and the checksum logic sit outside this block. The walker takes the base address and a load strobe as inputs. It reports a one-cycle pulse for each frame sent and for each aborted walk.

Top module: `txring_walker`

## Requirements
- R1: After a synchronous active-low reset the walker is idle. `busy`, `mem_req`, `out_valid`, `tx_done` and `scan_abort` are low, and `cur_ptr` is zero.
- R2: A `poll` pulse while idle starts a walk at `cur_ptr`. Every memory access is one 32-bit word. `mem_req`, `mem_we` and `mem_addr` hold steady until `mem_ready` is high, and read data is taken from `mem_rdata` in that same cycle.
- R3: Word 0 of a descriptor is its control word, and bit 31 of it is the hardware-ownership flag. A walk that reads a control word with bit 31 clear ends there: no write occurs and `cur_ptr` is unchanged.
- R4: Word 1 holds the buffer-1 length in bits 11:0 and the buffer-2 length in bits 27:16. Bits 15:12 and 31:28 are ignored. Word 2 is the buffer address, with its low two bits ignored. Buffer bytes are taken in ascending address order, and within a fetched word the least significant byte comes first.
- R5: A buffer-1 length above 2048 or a nonzero buffer-2 length aborts the walk. `scan_abort` pulses once, the descriptor is not written back and `cur_ptr` is unchanged.
- R6: A descriptor aborts the walk (same effects as R5) when the bytes already staged plus its buffer-1 length would reach or exceed 8192. An abort also discards the staged bytes, so the next frame starts empty.
- R7: Segments without bit 29 of the control word accumulate. On a descriptor with bit 29 set, the whole staged frame is sent on the byte stream with `out_last` high on its final byte only. `tx_done` then pulses once and the staging store is emptied. A frame with no bytes sends nothing but still pulses `tx_done`.
- R8: After each descriptor has been consumed, only its control word is written back. Bit 31 is cleared and all other bits are kept.
- R9: After a write-back, `cur_ptr` becomes `base_addr` if bit 21 of the control word is set, and otherwise advances by 32. A `ptr_load` pulse while idle loads `base_addr` into `cur_ptr`.
- R10: Any number of `poll` pulses during a walk cause exactly one further walk after the current one ends.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| poll | input | 1 | Poll-demand strobe |
| ptr_load | input | 1 | Load ring pointer from base address (idle only) |
| base_addr | input | ADDR_W | Ring base address |
| cur_ptr | output | ADDR_W | Current descriptor address |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts the request |
| out_valid | output | 1 | Frame byte valid |
| out_ready | input | 1 | Sink accepts the byte |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |
| tx_done | output | 1 | One-cycle pulse per frame sent |
| scan_abort | output | 1 | One-cycle pulse per aborted walk |

## Verification
Single-descriptor frames are run with lengths of one byte, one word, an odd count, zero and the 2048-byte ceiling. Some have junk in the ignored size bits and some have the end-of-ring flag, which separates length decoding, byte order and wrap-versus-advance. A three-segment frame shows that segments are joined into one stream with a single final-byte mark. A 8191-byte frame and an 8192-byte attempt bracket the frame limit, and the frame sent after the abort shows whether the discarded bytes leak into it. An unowned descriptor, two kinds of length violation and a burst of polls during a long walk cover the ways a walk ends or restarts. Memory and sink both stall on a fixed pattern throughout.

// File: rtl/txring_pkg.sv
package txring_pkg;

    // Walker sequencing states
    typedef enum logic [3:0] {
        S_IDLE,
        S_CTL,
        S_SIZE,
        S_BUF,
        S_CHECK,
        S_FETCH,
        S_PUSH,
        S_SEG,
        S_EMIT,
        S_WB
    } walk_state_t;

    localparam int unsigned DESC_BYTES = 32;
    localparam int unsigned OWN_BIT    = 31;
    localparam int unsigned LAST_BIT   = 29;
    localparam int unsigned WRAP_BIT   = 21;
    localparam int unsigned LEN_W      = 12;

endpackage

// File: rtl/txring_stage.sv
// Frame staging store: one byte written and one byte read per cycle.
// Built from four byte lanes so that each lane is a plain memory.
// Assumes: DEPTH is a power of two and a multiple of four; read is combinational.
module txring_stage #(
    parameter int unsigned DEPTH = 8192,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned WORDS = DEPTH / 4
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte
);

    logic [7:0] lane_q [4];

    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] arr [WORDS];

        // Store the byte into the lane that owns its low address bits
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx[1:0] == 2'(g))) begin
                arr[wr_idx[IDX_W-1:2]] <= wr_byte;
            end
        end

        assign lane_q[g] = arr[rd_idx[IDX_W-1:2]];
    end

    assign rd_byte = lane_q[rd_idx[1:0]];

endmodule

// File: rtl/txring_ptr.sv
// Ring pointer and poll latch.
// Holds the current descriptor address, loads it from the base on request
// (idle only), moves it after each write-back, and remembers polls that
// arrive during a walk.
// Assumes: adv_en is only raised while a walk is running.
module txring_ptr
    import txring_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll,
    input  logic              ptr_load,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              idle,
    input  logic              adv_en,
    input  logic              wrap,
    output logic              start,
    output logic [ADDR_W-1:0] cur_ptr
);

    logic pend;

    assign start = idle && (poll || pend);

    // Remember a poll seen mid-walk; drop it once a walk starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (start) begin
            pend <= 1'b0;
        end else if (poll) begin
            pend <= 1'b1;
        end
    end

    // Move the ring pointer on load or after a write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ptr <= '0;
        end else if (ptr_load && idle) begin
            cur_ptr <= base_addr;
        end else if (adv_en) begin
            cur_ptr <= wrap ? base_addr : cur_ptr + ADDR_W'(DESC_BYTES);
        end
    end

endmodule

// File: rtl/txring_seq.sv
// Descriptor sequencer: fetches control, size and address words, checks
// lengths, copies buffer bytes into the staging store, streams the frame
// on the last segment and writes the control word back.
// Assumes: buffer addresses are word aligned (low bits dropped); the memory
// returns read data in the cycle it raises ready.
module txring_seq
    import txring_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned FRAME_LIMIT = 8192,
    parameter int unsigned SEG_MAX     = 2048,
    localparam int unsigned IDX_W      = $clog2(FRAME_LIMIT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cur_ptr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ready,
    output logic              st_wr_en,
    output logic [IDX_W-1:0]  st_wr_idx,
    output logic [7:0]        st_wr_byte,
    output logic [IDX_W-1:0]  st_rd_idx,
    input  logic [7:0]        st_rd_byte,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic              adv_en,
    output logic              wrap,
    output logic              idle,
    output logic              tx_done,
    output logic              scan_abort
);

    localparam logic [LEN_W:0] SEG_MAX_V = (LEN_W+1)'(SEG_MAX);
    localparam logic [IDX_W:0] LIMIT_V   = (IDX_W+1)'(FRAME_LIMIT);

    walk_state_t       state;
    logic [31:0]       ctl;
    logic [LEN_W-1:0]  len1, len2, remain;
    logic [ADDR_W-1:0] fetch_addr;
    logic [31:0]       data_word;
    logic [1:0]        lane;
    logic [IDX_W-1:0]  acc, rd_pos;
    logic [IDX_W:0]    sum_len;
    logic              seg_bad;

    // Length rules for the descriptor just fetched
    assign sum_len = {1'b0, acc} + (IDX_W+1)'(len1);
    assign seg_bad = ({1'b0, len1} > SEG_MAX_V) || (len2 != '0) || (sum_len >= LIMIT_V);

    // Memory request decode from the current state
    assign mem_req   = (state == S_CTL) || (state == S_SIZE) || (state == S_BUF)
                    || (state == S_FETCH) || (state == S_WB);
    assign mem_we    = (state == S_WB);
    assign mem_wdata = {1'b0, ctl[30:0]};

    // Address of the word requested in each state
    always_comb begin
        case (state)
            S_SIZE:  mem_addr = cur_ptr + ADDR_W'(4);
            S_BUF:   mem_addr = cur_ptr + ADDR_W'(8);
            S_FETCH: mem_addr = fetch_addr;
            default: mem_addr = cur_ptr;
        endcase
    end

    assign st_wr_en   = (state == S_PUSH);
    assign st_wr_idx  = acc;
    assign st_wr_byte = data_word[{lane, 3'b000} +: 8];
    assign st_rd_idx  = rd_pos;

    assign out_valid = (state == S_EMIT);
    assign out_data  = st_rd_byte;
    assign out_last  = (state == S_EMIT) && (rd_pos == acc - IDX_W'(1));

    assign adv_en = (state == S_WB) && mem_ready;
    assign wrap   = ctl[WRAP_BIT];
    assign idle   = (state == S_IDLE);

    // Walk sequencing and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            ctl        <= '0;
            len1       <= '0;
            len2       <= '0;
            remain     <= '0;
            fetch_addr <= '0;
            data_word  <= '0;
            lane       <= '0;
            acc        <= '0;
            rd_pos     <= '0;
            tx_done    <= 1'b0;
            scan_abort <= 1'b0;
        end else begin
            tx_done    <= 1'b0;
            scan_abort <= 1'b0;
            case (state)
                S_IDLE: if (start) state <= S_CTL;
                S_CTL: if (mem_ready) begin
                    ctl   <= mem_rdata;
                    state <= mem_rdata[OWN_BIT] ? S_SIZE : S_IDLE;
                end
                S_SIZE: if (mem_ready) begin
                    len1  <= mem_rdata[LEN_W-1:0];
                    len2  <= mem_rdata[16 +: LEN_W];
                    state <= S_BUF;
                end
                S_BUF: if (mem_ready) begin
                    fetch_addr <= {mem_rdata[ADDR_W-1:2], 2'b00};
                    state      <= S_CHECK;
                end
                S_CHECK: begin
                    if (seg_bad) begin
                        scan_abort <= 1'b1;
                        acc        <= '0;
                        state      <= S_IDLE;
                    end else begin
                        remain <= len1;
                        state  <= (len1 == '0) ? S_SEG : S_FETCH;
                    end
                end
                S_FETCH: if (mem_ready) begin
                    data_word  <= mem_rdata;
                    lane       <= '0;
                    fetch_addr <= fetch_addr + ADDR_W'(4);
                    state      <= S_PUSH;
                end
                S_PUSH: begin
                    acc    <= acc + IDX_W'(1);
                    remain <= remain - LEN_W'(1);
                    lane   <= lane + 2'd1;
                    if (remain == LEN_W'(1)) begin
                        state <= S_SEG;
                    end else if (lane == 2'd3) begin
                        state <= S_FETCH;
                    end
                end
                S_SEG: begin
                    if (!ctl[LAST_BIT]) begin
                        state <= S_WB;
                    end else if (acc == '0) begin
                        tx_done <= 1'b1;
                        state   <= S_WB;
                    end else begin
                        rd_pos <= '0;
                        state  <= S_EMIT;
                    end
                end
                S_EMIT: if (out_ready) begin
                    if (out_last) begin
                        tx_done <= 1'b1;
                        acc     <= '0;
                        state   <= S_WB;
                    end else begin
                        rd_pos <= rd_pos + IDX_W'(1);
                    end
                end
                S_WB: if (mem_ready) state <= S_CTL;
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/txring_walker.sv
// Transmit descriptor ring walker, top level.
// Ties the pointer/poll unit, the descriptor sequencer and the staging store.
// Assumes: one outstanding memory word at a time; the sink may stall freely.
module txring_walker #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned FRAME_LIMIT = 8192,
    parameter int unsigned SEG_MAX     = 2048,
    localparam int unsigned IDX_W      = $clog2(FRAME_LIMIT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll,
    input  logic              ptr_load,
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic              tx_done,
    output logic              scan_abort
);

    logic             idle, start, adv_en, wrap;
    logic             st_wr_en;
    logic [IDX_W-1:0] st_wr_idx, st_rd_idx;
    logic [7:0]       st_wr_byte, st_rd_byte;

    assign busy = !idle;

    txring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .poll      (poll),
        .ptr_load  (ptr_load),
        .base_addr (base_addr),
        .idle      (idle),
        .adv_en    (adv_en),
        .wrap      (wrap),
        .start     (start),
        .cur_ptr   (cur_ptr)
    );

    txring_seq #(
        .ADDR_W      (ADDR_W),
        .FRAME_LIMIT (FRAME_LIMIT),
        .SEG_MAX     (SEG_MAX)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cur_ptr    (cur_ptr),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready),
        .st_wr_en   (st_wr_en),
        .st_wr_idx  (st_wr_idx),
        .st_wr_byte (st_wr_byte),
        .st_rd_idx  (st_rd_idx),
        .st_rd_byte (st_rd_byte),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_last   (out_last),
        .adv_en     (adv_en),
        .wrap       (wrap),
        .idle       (idle),
        .tx_done    (tx_done),
        .scan_abort (scan_abort)
    );

    txring_stage #(.DEPTH(FRAME_LIMIT)) u_stage (
        .clk     (clk),
        .wr_en   (st_wr_en),
        .wr_idx  (st_wr_idx),
        .wr_byte (st_wr_byte),
        .rd_idx  (st_rd_idx),
        .rd_byte (st_rd_byte)
    );

endmodule

// File: rtl/txring_walker_chk.sv
// Protocol checker for the ring walker, attached by bind.
// Assumes: observes top-level ports only.
module txring_walker_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ptr_load,
    input logic [ADDR_W-1:0] base_addr,
    input logic [ADDR_W-1:0] cur_ptr,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_data,
    input logic              out_last,
    input logic              tx_done,
    input logic              scan_abort
);

    // R2
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R8
    wb_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[31]);

    // R9
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ready && mem_wdata[21] |=> cur_ptr == $past(base_addr));

    // R9
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ready && !mem_wdata[21] |=> cur_ptr == $past(cur_ptr) + ADDR_W'(32));

    // R9
    ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_ptr) |-> $past(ptr_load && !busy) || $past(mem_req && mem_we && mem_ready));

    // R11
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R7
    evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_done && scan_abort));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !out_valid);

endmodule

bind txring_walker txring_walker_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/txring_walker_tb.sv
`timescale 1ns/1ps
module txring_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        poll = 1'b0;
    logic        ptr_load = 1'b0;
    logic [31:0] base_addr = '0;
    logic [31:0] cur_ptr;
    logic        busy;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        out_valid, out_ready, out_last;
    logic [7:0]  out_data;
    logic        tx_done, scan_abort;

    always #4 clk = ~clk;

    txring_walker u_dut (.*);

    // memory model and stall patterns
    logic [31:0] ram [1024];
    logic [7:0]  cyc = '0;
    always @(posedge clk) cyc <= cyc + 8'd1;
    assign mem_ready = (cyc[1:0] != 2'b11);
    assign out_ready = (cyc[2:0] != 3'b101);
    assign mem_rdata = ram[mem_addr[11:2]];
    always @(posedge clk) if (mem_req && mem_we && mem_ready) ram[mem_addr[11:2]] <= mem_wdata;

    // observation counters (never cleared; tests use differences)
    logic [7:0]  cap [4096];
    int ncap = 0, nlast = 0, ndone = 0, nabort = 0, nwr = 0, nwatch = 0;
    int req_bad = 0, hold_bad = 0;
    logic [31:0] watch_addr = 32'h220;
    logic        p_stall = 1'b0, p_we = 1'b0, p_ostall = 1'b0, p_olast = 1'b0;
    logic [31:0] p_addr = '0;
    logic [7:0]  p_odata = '0;

    always @(posedge clk) begin
        if (out_valid && out_ready) begin
            cap[ncap % 4096] <= out_data;
            ncap <= ncap + 1;
            if (out_last) nlast <= nlast + 1;
        end
        if (tx_done) ndone <= ndone + 1;
        if (scan_abort) nabort <= nabort + 1;
        if (mem_req && mem_we && mem_ready) nwr <= nwr + 1;
        if (mem_req && !mem_we && mem_ready && mem_addr == watch_addr) nwatch <= nwatch + 1;
        if (rst_n && p_stall && (!mem_req || mem_addr != p_addr || mem_we != p_we)) req_bad <= req_bad + 1;
        if (rst_n && p_ostall && (!out_valid || out_data != p_odata || out_last != p_olast)) hold_bad <= hold_bad + 1;
        p_stall  <= mem_req && !mem_ready;
        p_addr   <= mem_addr;
        p_we     <= mem_we;
        p_ostall <= out_valid && !out_ready;
        p_odata  <= out_data;
        p_olast  <= out_last;
    end

    int nchk = 0, nerr = 0;
    logic [7:0] exp_frm [8192];
    int exp_len = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic poke8(input int a, input logic [7:0] v);
        ram[a >> 2][(a % 4) * 8 +: 8] = v;
    endtask

    task automatic put_desc(input int a, input logic [31:0] ctl, input logic [31:0] sz, input logic [31:0] buf_a);
        ram[a >> 2] = ctl;
        ram[(a >> 2) + 1] = sz;
        ram[(a >> 2) + 2] = buf_a;
        for (int i = 3; i < 8; i++) ram[(a >> 2) + i] = '0;
    endtask

    task automatic fill_buf(input int a, input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) poke8(a + i, seed + 8'(i));
    endtask

    task automatic add_seg(input logic [7:0] seed, input int n);
        for (int i = 0; i < n; i++) exp_frm[exp_len + i] = seed + 8'(i);
        exp_len += n;
    endtask

    task automatic cmp_frame(input string req, input int c0, input int n);
        int bad;
        bad = 0;
        for (int i = (n > 4096 ? n - 4096 : 0); i < n; i++)
            if (cap[(c0 + i) % 4096] !== exp_frm[i]) bad++;
        chk(req, bad, 0);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_scan();
        @(negedge clk) poll = 1'b1;
        @(negedge clk) poll = 1'b0;
        wait_idle();
    endtask

    task automatic load_ptr(input logic [31:0] b);
        @(negedge clk) begin base_addr = b; ptr_load = 1'b1; end
        @(negedge clk) ptr_load = 1'b0;
    endtask

    typedef struct packed {
        logic [11:0] len;
        logic [3:0]  junk;
        logic        eor;
        logic [7:0]  seed;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{12'd1,    4'h0, 1'b0, 8'h10},
        '{12'd4,    4'hA, 1'b0, 8'h33},
        '{12'd7,    4'h0, 1'b1, 8'h5C},
        '{12'd0,    4'h0, 1'b0, 8'h00},
        '{12'd2048, 4'hF, 1'b0, 8'hC1},
        '{12'd13,   4'h0, 1'b1, 8'h77}
    };

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual busy=%0d expected run to finish", busy);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int c0, l0, d0, a0, w0, h0;
        logic [31:0] exp_ptr, ctl;
        for (int i = 0; i < 1024; i++) ram[i] = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 out_valid", out_valid, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cur_ptr", cur_ptr, 0);
        chk("R1 events", {tx_done, scan_abort}, 0);

        // table of single-descriptor frames
        exp_ptr = 32'h0;
        for (int k = 0; k < NVEC; k++) begin
            vec_t v;
            v = VECS[k];
            ctl = 32'hA000_0A5C | (v.eor ? 32'h0020_0000 : 32'h0);
            put_desc(int'(exp_ptr), ctl, {16'h0, v.junk, v.len}, 32'h400);
            put_desc(int'(exp_ptr) + 32, 32'h0, 32'h0, 32'h0);
            if (v.eor) ram[0] = 32'h0;
            fill_buf(32'h400, int'(v.len), v.seed);
            exp_len = 0;
            add_seg(v.seed, int'(v.len));
            c0 = ncap; l0 = nlast; d0 = ndone;
            run_scan();
            chk("R4 R7 frame length", ncap - c0, v.len);
            cmp_frame("R4 frame bytes", c0, int'(v.len));
            chk("R7 last flags", nlast - l0, (v.len != 0) ? 1 : 0);
            chk("R7 tx_done pulses", ndone - d0, 1);
            chk("R8 written control word", ram[exp_ptr >> 2], ctl & 32'h7FFF_FFFF);
            exp_ptr = v.eor ? 32'h0 : exp_ptr + 32;
            chk("R9 pointer after descriptor", cur_ptr, exp_ptr);
        end

        // R9 pointer load, R7 multi-segment frame
        load_ptr(32'h100);
        chk("R9 ptr_load", cur_ptr, 32'h100);
        put_desc(32'h100, 32'h8000_0000, 32'd3, 32'h400);
        put_desc(32'h120, 32'h8000_0000, 32'd6, 32'h501);
        put_desc(32'h140, 32'hA020_0000, 32'd2, 32'h600);
        fill_buf(32'h400, 3, 8'h20);
        fill_buf(32'h500, 6, 8'h40);
        fill_buf(32'h600, 2, 8'h60);
        exp_len = 0;
        add_seg(8'h20, 3); add_seg(8'h40, 6); add_seg(8'h60, 2);
        c0 = ncap; l0 = nlast; d0 = ndone;
        run_scan();
        chk("R7 joined frame length", ncap - c0, 11);
        cmp_frame("R7 R4 joined frame bytes", c0, 11);
        chk("R7 single last flag", nlast - l0, 1);
        chk("R7 single tx_done", ndone - d0, 1);
        chk("R8 segment 1 returned", ram[32'h100 >> 2], 32'h0000_0000);
        chk("R8 segment 3 returned", ram[32'h140 >> 2], 32'h2020_0000);
        chk("R9 wrap to base", cur_ptr, 32'h100);

        // R3 unowned descriptor stops without writes
        w0 = nwr;
        run_scan();
        chk("R3 no write on unowned", nwr - w0, 0);
        chk("R3 pointer kept", cur_ptr, 32'h100);

        // R5 buffer-1 too long
        put_desc(32'h100, 32'hA000_0000, 32'h0000_0801, 32'h400);
        a0 = nabort; w0 = nwr; c0 = ncap;
        run_scan();
        chk("R5 abort on long buffer 1", nabort - a0, 1);
        chk("R5 no write-back", nwr - w0, 0);
        chk("R5 ownership kept", ram[32'h100 >> 2], 32'hA000_0000);
        chk("R5 pointer kept", cur_ptr, 32'h100);
        chk("R5 nothing sent", ncap - c0, 0);

        // R5 nonzero buffer-2
        put_desc(32'h100, 32'hA000_0000, 32'h0001_0004, 32'h400);
        a0 = nabort; w0 = nwr;
        run_scan();
        chk("R5 abort on buffer 2", nabort - a0, 1);
        chk("R5 no write-back buffer 2", nwr - w0, 0);

        // R6 largest frame below the limit
        load_ptr(32'h200);
        fill_buf(32'h400, 2048, 8'h05);
        put_desc(32'h200, 32'h8000_0000, 32'd2048, 32'h400);
        put_desc(32'h220, 32'h8000_0000, 32'd2048, 32'h400);
        put_desc(32'h240, 32'h8000_0000, 32'd2048, 32'h400);
        put_desc(32'h260, 32'hA020_0000, 32'd2047, 32'h400);
        exp_len = 0;
        add_seg(8'h05, 2048); add_seg(8'h05, 2048); add_seg(8'h05, 2048); add_seg(8'h05, 2047);
        c0 = ncap; a0 = nabort;
        run_scan();
        chk("R6 8191-byte frame length", ncap - c0, 8191);
        cmp_frame("R6 8191-byte frame tail", c0, 8191);
        chk("R6 no abort below limit", nabort - a0, 0);

        // R6 reaching the limit aborts
        put_desc(32'h200, 32'h8000_0000, 32'd2048, 32'h400);
        put_desc(32'h220, 32'h8000_0000, 32'd2048, 32'h400);
        put_desc(32'h240, 32'h8000_0000, 32'd2048, 32'h400);
        put_desc(32'h260, 32'hA020_0000, 32'd2048, 32'h400);
        c0 = ncap; a0 = nabort;
        run_scan();
        chk("R6 abort at limit", nabort - a0, 1);
        chk("R6 earlier segments returned", ram[32'h240 >> 2], 32'h0);
        chk("R6 aborting descriptor kept", ram[32'h260 >> 2], 32'hA020_0000);
        chk("R6 pointer at aborting descriptor", cur_ptr, 32'h260);
        chk("R6 nothing sent on abort", ncap - c0, 0);
        put_desc(32'h260, 32'hA020_0000, 32'd5, 32'h400);
        fill_buf(32'h400, 5, 8'h90);
        exp_len = 0;
        add_seg(8'h90, 5);
        c0 = ncap;
        run_scan();
        chk("R6 staging emptied by abort", ncap - c0, 5);
        cmp_frame("R6 frame after abort", c0, 5);
        chk("R9 wrap after limit test", cur_ptr, 32'h200);

        // R10 polls during a walk give one extra walk
        put_desc(32'h200, 32'hA000_0000, 32'd40, 32'h400);
        h0 = nwatch; d0 = ndone;
        @(negedge clk) poll = 1'b1;
        @(negedge clk) poll = 1'b0;
        repeat (10) @(negedge clk);
        poll = 1'b1;
        @(negedge clk) poll = 1'b0;
        repeat (5) @(negedge clk);
        poll = 1'b1;
        @(negedge clk) poll = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R10 one extra walk", nwatch - h0, 2);
        chk("R10 one frame", ndone - d0, 1);
        chk("R10 idle at end", busy, 0);

        chk("R2 request held under stall", req_bad, 0);
        chk("R11 stream held under stall", hold_bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule